// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block sits on the outbound path from a local bus master toward a PCI port and rewrites request addresses. The upper nibble of the request address is disregarded. The next bit splits the space into a 128MB PCI aperture and everything else. For aperture requests, a 3-bit field picks one of eight 16MB windows. That field is then cleared, so only the 24-bit in-window offset remains, and the programmed 32-bit offset of the selected window is added to it.

Requests outside the aperture leave the block with their original address and the hit flag low. Requests marked as inbound, meaning a device acting as master, also pass through untouched. A small write port loads the eight offsets. After reset the windows map the aperture one-to-one onto 0x10000000..0x17FFFFFF.

Top module: `ob_addr_xlate`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted request, rsp_valid_o, rsp_pci_hit_o and rsp_addr_o read 0. Reset loads window n with 0x10000000 + (n << 24).
- R2: rsp_valid_o equals req_valid_i sampled at the previous rising clock edge, giving one cycle of latency. A response is produced for every accepted request.
- R3: Bits 31:28 of req_addr_i have no effect on the hit flag or on the translated address of an aperture request.
- R4: An outbound request (req_inbound_i = 0) with req_addr_i[27] = 0 is a PCI hit, so rsp_pci_hit_o = 1.
- R5: A request with req_addr_i[27] = 1 returns rsp_pci_hit_o = 0 and rsp_addr_o equal to the full original req_addr_i.
- R6: For a PCI hit, rsp_addr_o = window[req_addr_i[26:24]] + req_addr_i[23:0]. The offset is added, not concatenated.
- R7: cfg_we_i = 1 writes cfg_data_i into window cfg_idx_i at the clock edge. A request sampled at that same edge still uses the old value. Requests sampled at later edges use the new value.
- R8: The addition wraps modulo 2^32, and no carry is reported.
- R9: A request with req_inbound_i = 1 returns rsp_pci_hit_o = 0 and rsp_addr_o equal to req_addr_i, whatever the value of bit 27.
- R10: With reset offsets, 0x100000ff translates to 0x100000ff. With window 2 at 0x12000000, 0x120000ff translates to 0x120000ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request address |
| req_inbound_i | input | 1 | Request from a device master; no translation |
| cfg_we_i | input | 1 | Window offset write strobe |
| cfg_idx_i | input | 3 | Window index to write |
| cfg_data_i | input | 32 | Window offset value |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pci_hit_o | output | 1 | Request targeted the PCI aperture |
| rsp_addr_o | output | 32 | Translated or passed-through address |

## Verification
Every response is due exactly one rising edge after the request is sampled. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which comes half a period after the edge that registers them. A window write goes through the same edge. The bench therefore checks a request driven in the same half-cycle as a write against the old offset, and the request that follows against the new one. After each request the bench drops the valid input and checks one cycle later that rsp_valid_o has fallen.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic {
    TGT_PCI   = 1'b0,
    TGT_LOCAL = 1'b1
  } tgt_e;

  localparam int unsigned ADDR_W_DEF   = 32;
  localparam int unsigned NUM_WIN_DEF  = 8;
  localparam int unsigned WIN_BITS_DEF = 24;
endpackage

// File: rtl/xlate_win_regs.sv
module xlate_win_regs #(
  parameter int unsigned ADDR_W   = xlate_pkg::ADDR_W_DEF,
  parameter int unsigned NUM_WIN  = xlate_pkg::NUM_WIN_DEF,
  parameter int unsigned WIN_BITS = xlate_pkg::WIN_BITS_DEF,
  parameter logic [ADDR_W-1:0] RST_BASE = 32'h1000_0000,
  localparam int unsigned SEL_W   = $clog2(NUM_WIN)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                idx_i,
  input  logic [ADDR_W-1:0]               data_i,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_o
);
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    localparam logic [ADDR_W-1:0] RST_VAL = RST_BASE + (ADDR_W'(n) << WIN_BITS);
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= RST_VAL;
      else if (we_i && idx_i == SEL_W'(n))      q <= data_i;
    end
    assign win_o[n] = q;
  end

  // R7: a write is visible in the register one edge later
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> win_o[$past(idx_i)] == $past(data_i));
  // R7: windows without a write keep their value
  a_r7_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(win_o));
endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath #(
  parameter int unsigned ADDR_W   = xlate_pkg::ADDR_W_DEF,
  parameter int unsigned NUM_WIN  = xlate_pkg::NUM_WIN_DEF,
  parameter int unsigned WIN_BITS = xlate_pkg::WIN_BITS_DEF,
  localparam int unsigned SEL_W   = $clog2(NUM_WIN),
  localparam int unsigned TGT_BIT = WIN_BITS + SEL_W
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            inbound_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_i,
  output logic                            hit_o,
  output logic [ADDR_W-1:0]               addr_o
);
  import xlate_pkg::*;

  tgt_e               tgt;
  logic [SEL_W-1:0]   sel;
  logic [ADDR_W-1:0]  in_off;
  logic [ADDR_W-1:0]  xlated;

  always_comb begin
    tgt    = tgt_e'(addr_i[TGT_BIT]);
    sel    = addr_i[WIN_BITS +: SEL_W];
    in_off = {{(ADDR_W-WIN_BITS){1'b0}}, addr_i[WIN_BITS-1:0]};
    xlated = win_i[sel] + in_off;  // wraps mod 2^ADDR_W
    hit_o  = !inbound_i && (tgt == TGT_PCI);
    addr_o = hit_o ? xlated : addr_i;
  end
endmodule

// File: rtl/ob_addr_xlate.sv
module ob_addr_xlate #(
  parameter int unsigned ADDR_W   = xlate_pkg::ADDR_W_DEF,
  parameter int unsigned NUM_WIN  = xlate_pkg::NUM_WIN_DEF,
  parameter int unsigned WIN_BITS = xlate_pkg::WIN_BITS_DEF,
  parameter logic [ADDR_W-1:0] RST_BASE = 32'h1000_0000,
  localparam int unsigned SEL_W   = $clog2(NUM_WIN),
  localparam int unsigned TGT_BIT = WIN_BITS + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_inbound_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_pci_hit_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] win;
  logic                           hit_d;
  logic [ADDR_W-1:0]              addr_d;

  xlate_win_regs #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .RST_BASE(RST_BASE)
  ) i_win_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .data_i (cfg_data_i),
    .win_o  (win)
  );

  xlate_datapath #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)
  ) i_datapath (
    .addr_i    (req_addr_i),
    .inbound_i (req_inbound_i),
    .win_i     (win),
    .hit_o     (hit_d),
    .addr_o    (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_pci_hit_o <= 1'b0;
      rsp_addr_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_pci_hit_o <= hit_d;
        rsp_addr_o    <= addr_d;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r4_aperture_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_inbound_i && !req_addr_i[TGT_BIT]) |=> rsp_pci_hit_o);
  a_r5_local_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[TGT_BIT])
      |=> (!rsp_pci_hit_o && rsp_addr_o == $past(req_addr_i)));
  a_r9_inbound_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_inbound_i)
      |=> (!rsp_pci_hit_o && rsp_addr_o == $past(req_addr_i)));
  a_r6_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_inbound_i && !req_addr_i[TGT_BIT] && !cfg_we_i)
      |=> rsp_addr_o == $past(win[req_addr_i[WIN_BITS +: SEL_W]]
                              + ADDR_W'(req_addr_i[WIN_BITS-1:0])));
  a_r1_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(rsp_addr_o) && $stable(rsp_pci_hit_o));
endmodule

// File: tb/test_ob_addr_xlate.sv
`timescale 1ns/1ps
module test_ob_addr_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_inbound_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_pci_hit_o;
  logic [31:0] rsp_addr_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] model_win [8];

  always #10 clk_i = ~clk_i;

  ob_addr_xlate i_ob_addr_xlate (.*);

  task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] expect_of(logic [31:0] a, logic inb);
    if (inb || a[27]) return {1'b0, a};
    return {1'b1, model_win[a[26:24]] + {8'h00, a[23:0]}};
  endfunction

  // drive one request, check response one edge later, then check valid drops
  task automatic send(string req, logic [31:0] a, logic inb);
    req_valid_i = 1'b1; req_addr_i = a; req_inbound_i = inb;
    @(negedge clk_i);
    chk({req, " valid"}, {32'h0, rsp_valid_o}, 33'h1);
    chk(req, {rsp_pci_hit_o, rsp_addr_o}, expect_of(a, inb));
    req_valid_i = 1'b0; req_inbound_i = 1'b0;
    @(negedge clk_i);
    chk("R2 idle", {32'h0, rsp_valid_o}, 33'h0);
  endtask

  task automatic write_win(logic [2:0] idx, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model_win[idx] = d;
  endtask

  task automatic t_reset;
    chk("R1 reset", {rsp_pci_hit_o, rsp_addr_o}, 33'h0);
    chk("R1 reset valid", {32'h0, rsp_valid_o}, 33'h0);
  endtask

  task automatic t_examples;
    send("R10 default map", 32'h1000_00ff, 1'b0);
    chk("R10 value", {1'b0, rsp_addr_o}, {1'b0, 32'h1000_00ff});
    write_win(3'd2, 32'h1200_0000);
    send("R10 window2", 32'h1200_00ff, 1'b0);
  endtask

  task automatic t_upper_nibble;
    send("R3 nibble F", 32'hF000_00ff, 1'b0);
    send("R3 nibble 5", 32'h5300_00ff, 1'b0);
    send("R4 hit", 32'h0412_3456, 1'b0);
  endtask

  task automatic t_local;
    send("R5 local", 32'h0800_1234, 1'b0);
    send("R5 local top", 32'hFF00_0000, 1'b0);
  endtask

  task automatic t_inbound;
    send("R9 inbound aperture", 32'h0200_0010, 1'b1);
    send("R9 inbound local", 32'h0C00_0010, 1'b1);
  endtask

  task automatic t_write_timing;
    logic [31:0] old5 = model_win[5];
    cfg_we_i = 1'b1; cfg_idx_i = 3'd5; cfg_data_i = 32'hABC0_0000;
    req_valid_i = 1'b1; req_addr_i = 32'h0500_0010; req_inbound_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model_win[5] = 32'hABC0_0000;
    chk("R7 same edge old", {rsp_pci_hit_o, rsp_addr_o}, {1'b1, old5 + 32'h10});
    req_valid_i = 1'b0;
    @(negedge clk_i);
    send("R7 new value", 32'h0500_0010, 1'b0);
  endtask

  task automatic t_wrap;
    write_win(3'd7, 32'hFFFF_FF00);
    send("R8 wrap", 32'h0700_0200, 1'b0);
    chk("R8 value", {rsp_pci_hit_o, rsp_addr_o}, {1'b1, 32'h0000_0100});
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 8; n++)
      write_win(3'(n), 32'h2000_0000 + 32'(n) * 32'h0111_0000);
    for (int n = 0; n < 8; n++)
      send("R6 window sweep", {4'hA, 1'b0, 3'(n), 24'hFF_FFF0 - 24'(n)}, 1'b0);
  endtask

  task automatic t_back_to_back;
    req_valid_i = 1'b1; req_addr_i = 32'h0100_0004; req_inbound_i = 1'b0;
    @(negedge clk_i);
    chk("R2 b2b first", {rsp_pci_hit_o, rsp_addr_o}, expect_of(32'h0100_0004, 1'b0));
    req_addr_i = 32'h0900_0004;
    @(negedge clk_i);
    chk("R2 b2b valid", {32'h0, rsp_valid_o}, 33'h1);
    chk("R2 b2b second", {rsp_pci_hit_o, rsp_addr_o}, expect_of(32'h0900_0004, 1'b0));
    req_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) model_win[n] = 32'h1000_0000 + (32'(n) << 24);
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_examples();
    t_upper_nibble();
    t_local();
    t_inbound();
    t_write_timing();
    t_wrap();
    t_sweep();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule